// File: doc/BRIEF.md
# Shared Functional Clock Domain Controller

This block runs one functional clock that several peripheral modules share. Every module has its own enable bit, and the domain clock runs while at least one module still needs it. The clock stops only when every module has gone idle and no wake-up event is pending. Each module is set to one of three idle behaviours. A forced-idle module releases its claim as soon as its enable is cleared. A smart-idle module raises an idle request and keeps its claim until it acknowledges. A no-idle module never releases its claim on its own.

Software writes the controller through a small register write port. A select bit picks one of two source clocks and a divider field scales the chosen source. The sources arrive as single-cycle tick strobes in the controller clock domain, and the delivered functional clock is a strobe of the same kind, so it never contains a partial period. A select or divider change is accepted only while the clock is fully stopped. A write at any other time is dropped and sets a sticky error flag. A running flag shows whether the gate has reached the source domain, and each module gets a 2-bit activity code.

Register map (write only): address 0 holds the enables, with bit i belonging to module i. Address 1 holds the clock configuration, with bit 0 as the source select and bits DIV_W:1 as the divide value minus one. Address 2 holds the idle modes, two bits per module at bits 2i+1:2i. A write to address 3 has no effect.

Top module: `shared_fclk_ctrl`

## Requirements
- R1: Writing a 1 to a module's enable bit starts a stopped clock. The gate turns on at the next edge, and clk_running rises once that gate has crossed a 2-stage synchronizer clocked by ticks of the selected source.
- R2: While the clock is on, it stays on as long as any module holds a claim or wakeup is high. It is gated only when no module holds a claim and wakeup is low.
- R3: Idle mode 00 is forced-idle. Clearing the enable of such a module drops its claim at the next edge, and the clock stops when no other claim remains.
- R4: Idle mode 01 or 11 is smart-idle. Clearing the enable raises idle_req for that module, and its claim stays until idle_ack is seen high. Setting the enable again cancels the request.
- R5: Idle mode 10 is no-idle. The module keeps its claim after its enable is cleared, until its mode is changed.
- R6: Select 0 chooses src1_tick and select 1 chooses src2_tick. While running, fclk_tick pulses once every (divide field + 1) selected ticks. No pulse appears while clk_running is low.
- R7: A configuration write is dropped while any enable is set or the clock is not fully stopped. Such a write sets cfg_err, which stays set until reset.
- R8: clk_running falls only after a low gate has crossed the same 2-stage synchronizer, one stage per selected tick.
- R9: The activity code of module i is act_status[2i+1:2i]. It is 00 when the clock is not running, 01 when running and claimed, 10 when running and the module is idle, and 11 when running with the idle handshake pending. It is registered from the previous cycle's state.
- R10: After reset, all enables, modes and configuration are zero, and every output is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register address |
| wr_data | input | 8 | Register write data |
| src1_tick | input | 1 | Tick strobe of source clock 1 |
| src2_tick | input | 1 | Tick strobe of source clock 2 |
| wakeup | input | 1 | Pending wake-up event, holds the clock on |
| idle_ack | input | 4 | Per-module idle acknowledge |
| idle_req | output | 4 | Per-module idle request (smart-idle handshake) |
| fclk_tick | output | 1 | Gated, divided functional clock strobe |
| clk_running | output | 1 | Synchronized clock-running status |
| act_status | output | 8 | Per-module 2-bit activity code |
| cfg_err | output | 1 | Sticky flag for a rejected configuration write |

## Verification
A module that is stuck in a wrong idle state shows up within two cycles as a wrong act_status code or idle_req bit. It also either holds clk_running high or drops it a few source ticks early. A corrupted divider count or synchronizer stage moves fclk_tick off its expected cycle at the first selected tick after the fault. The error shows at the very next pulse, and a per-cycle reference comparison catches it. A configuration write that slips through while the clock is busy changes the tick rate in the following window and leaves cfg_err low.

// File: rtl/fcd_pkg.sv
package fcd_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'b00,
    ST_ACTIVE = 2'b01,
    ST_WAIT   = 2'b10
  } mod_state_e;

  localparam logic [1:0] MODE_FORCED = 2'b00;
  localparam logic [1:0] MODE_NOIDLE = 2'b10;

  localparam logic [1:0] ACT_OFF     = 2'b00;
  localparam logic [1:0] ACT_CLAIMED = 2'b01;
  localparam logic [1:0] ACT_IDLE    = 2'b10;
  localparam logic [1:0] ACT_PENDING = 2'b11;

  function automatic logic [1:0] act_code(input mod_state_e s, input logic run);
    if (!run)                 return ACT_OFF;
    else if (s == ST_ACTIVE)  return ACT_CLAIMED;
    else if (s == ST_WAIT)    return ACT_PENDING;
    else                      return ACT_IDLE;
  endfunction

endpackage

// File: rtl/fcd_regs.sv
module fcd_regs #(
  parameter int N_MOD  = 4,
  parameter int DIV_W  = 3,
  parameter int ADDR_W = 2,
  parameter int DATA_W = 2 * N_MOD
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              busy,
  output logic [N_MOD-1:0]  en_q,
  output logic              sel_q,
  output logic [DIV_W-1:0]  div_q,
  output logic [DATA_W-1:0] mode_q,
  output logic              err_q
);

  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_MODE = ADDR_W'(2);

  logic cfg_locked;
  assign cfg_locked = (|en_q) | busy;

  always_ff @(posedge clk) begin
    if (rst) begin
      en_q   <= '0;
      sel_q  <= 1'b0;
      div_q  <= '0;
      mode_q <= '0;
      err_q  <= 1'b0;
    end else if (wr_en) begin
      case (wr_addr)
        A_EN:   en_q <= wr_data[N_MOD-1:0];
        A_CFG: begin
          if (cfg_locked) err_q <= 1'b1;
          else {div_q, sel_q} <= wr_data[DIV_W:0];
        end
        A_MODE: mode_q <= wr_data;
        default: ;
      endcase
    end
  end

  AST_CFG_FROZEN: assert property (@(posedge clk) disable iff (rst)
    cfg_locked |=> ($stable(sel_q) && $stable(div_q))); // R7
  AST_ERR_STICKY: assert property (@(posedge clk) disable iff (rst)
    err_q |=> err_q); // R7
  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    $rose(err_q) |-> $past(wr_en && (wr_addr == A_CFG))); // R7

endmodule

// File: rtl/fcd_idle_fsm.sv
module fcd_idle_fsm
  import fcd_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic       en,
  input  logic [1:0] mode,
  input  logic       ack,
  output mod_state_e state_o,
  output logic       claim,
  output logic       idle_req
);

  mod_state_e st;

  always_ff @(posedge clk) begin
    if (rst) begin
      st <= ST_IDLE;
    end else begin
      case (st)
        ST_IDLE:   if (en) st <= ST_ACTIVE;
        ST_ACTIVE: begin
          if (!en) begin
            if (mode == MODE_NOIDLE)      st <= ST_ACTIVE;
            else if (mode[0])             st <= ST_WAIT;
            else                          st <= ST_IDLE;
          end
        end
        ST_WAIT: begin
          if (en)       st <= ST_ACTIVE;
          else if (ack) st <= ST_IDLE;
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign state_o  = st;
  assign claim    = (st != ST_IDLE);
  assign idle_req = (st == ST_WAIT);

  AST_FORCED_DROP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACTIVE && !en && mode == MODE_FORCED) |=> (st == ST_IDLE)); // R3
  AST_SMART_HOLD: assert property (@(posedge clk) disable iff (rst)
    (st == ST_WAIT && !en && !ack) |=> (st == ST_WAIT)); // R4
  AST_NOIDLE_KEEP: assert property (@(posedge clk) disable iff (rst)
    (st == ST_ACTIVE && mode == MODE_NOIDLE) |=> (st == ST_ACTIVE)); // R5

endmodule

// File: rtl/fcd_gate.sv
module fcd_gate #(
  parameter int DIV_W       = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             any_claim,
  input  logic             wakeup,
  input  logic             src1_tick,
  input  logic             src2_tick,
  input  logic             sel,
  input  logic [DIV_W-1:0] div,
  output logic             busy,
  output logic             running,
  output logic             fclk_tick
);

  logic                   gate_q;
  logic [SYNC_STAGES-1:0] sync_q;
  logic [DIV_W-1:0]       cnt_q;
  logic                   tick_q;
  logic                   sel_tick;

  assign sel_tick = sel ? src2_tick : src1_tick;
  assign running  = sync_q[SYNC_STAGES-1];
  assign busy     = gate_q | (|sync_q);
  assign fclk_tick = tick_q;

  always_ff @(posedge clk) begin
    if (rst) gate_q <= 1'b0;
    else     gate_q <= any_claim | (gate_q & wakeup);
  end

  generate
    if (SYNC_STAGES > 1) begin : g_shift
      always_ff @(posedge clk) begin
        if (rst)           sync_q <= '0;
        else if (sel_tick) sync_q <= {sync_q[SYNC_STAGES-2:0], gate_q};
      end
    end else begin : g_single
      always_ff @(posedge clk) begin
        if (rst)           sync_q <= '0;
        else if (sel_tick) sync_q <= gate_q;
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q  <= '0;
      tick_q <= 1'b0;
    end else begin
      tick_q <= running & sel_tick & (cnt_q == div);
      if (!running)      cnt_q <= '0;
      else if (sel_tick) cnt_q <= (cnt_q == div) ? '0 : cnt_q + DIV_W'(1);
    end
  end

  AST_HOLD_ON: assert property (@(posedge clk) disable iff (rst)
    (gate_q && (any_claim || wakeup)) |=> gate_q); // R2
  AST_SYNC_RISE: assert property (@(posedge clk) disable iff (rst)
    $rose(running) |-> $past(sync_q[SYNC_STAGES-2] && sel_tick)); // R1
  AST_SYNC_FALL: assert property (@(posedge clk) disable iff (rst)
    $fell(running) |-> $past(!sync_q[SYNC_STAGES-2] && sel_tick)); // R8
  AST_TICK_RUN: assert property (@(posedge clk) disable iff (rst)
    tick_q |-> $past(running && sel_tick)); // R6
  AST_CNT_RANGE: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= div); // R6

endmodule

// File: rtl/shared_fclk_ctrl.sv
module shared_fclk_ctrl
  import fcd_pkg::*;
#(
  parameter int N_MOD       = 4,
  parameter int DIV_W       = 3,
  parameter int ADDR_W      = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_en,
  input  logic [ADDR_W-1:0]  wr_addr,
  input  logic [2*N_MOD-1:0] wr_data,
  input  logic               src1_tick,
  input  logic               src2_tick,
  input  logic               wakeup,
  input  logic [N_MOD-1:0]   idle_ack,
  output logic [N_MOD-1:0]   idle_req,
  output logic               fclk_tick,
  output logic               clk_running,
  output logic [2*N_MOD-1:0] act_status,
  output logic               cfg_err
);

  localparam int DATA_W = 2 * N_MOD;

  logic [N_MOD-1:0]  en_q;
  logic              sel_q;
  logic [DIV_W-1:0]  div_q;
  logic [DATA_W-1:0] mode_q;
  logic              busy;
  logic [N_MOD-1:0]  claim;
  mod_state_e        st [N_MOD];
  logic [DATA_W-1:0] act_q;

  fcd_regs #(
    .N_MOD(N_MOD), .DIV_W(DIV_W), .ADDR_W(ADDR_W), .DATA_W(DATA_W)
  ) u_regs (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .busy(busy), .en_q(en_q), .sel_q(sel_q), .div_q(div_q), .mode_q(mode_q),
    .err_q(cfg_err)
  );

  generate
    for (genvar i = 0; i < N_MOD; i++) begin : g_mod
      fcd_idle_fsm u_fsm (
        .clk(clk), .rst(rst), .en(en_q[i]), .mode(mode_q[2*i +: 2]),
        .ack(idle_ack[i]), .state_o(st[i]), .claim(claim[i]),
        .idle_req(idle_req[i])
      );

      always_ff @(posedge clk) begin
        if (rst) act_q[2*i +: 2] <= ACT_OFF;
        else     act_q[2*i +: 2] <= act_code(st[i], clk_running);
      end
    end
  endgenerate

  fcd_gate #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_gate (
    .clk(clk), .rst(rst), .any_claim(|claim), .wakeup(wakeup),
    .src1_tick(src1_tick), .src2_tick(src2_tick), .sel(sel_q), .div(div_q),
    .busy(busy), .running(clk_running), .fclk_tick(fclk_tick)
  );

  assign act_status = act_q;

  AST_ACT_OFF: assert property (@(posedge clk) disable iff (rst)
    !$past(clk_running) |-> (act_status == '0)); // R9

endmodule

// File: tb/shared_fclk_ctrl_test.sv
`timescale 1ns/1ps
module shared_fclk_ctrl_test;
  localparam int N = 4;

  logic clk = 0, rst = 1;
  logic wr_en = 0;
  logic [1:0] wr_addr = 0;
  logic [7:0] wr_data = 0;
  logic src1 = 0, src2 = 1, wakeup = 0;
  logic [N-1:0] ack = 0;
  logic [N-1:0] idle_req;
  logic fclk, running, err;
  logic [2*N-1:0] act;

  shared_fclk_ctrl uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .src1_tick(src1), .src2_tick(src2), .wakeup(wakeup), .idle_ack(ack),
    .idle_req(idle_req), .fclk_tick(fclk), .clk_running(running),
    .act_status(act), .cfg_err(err)
  );

  always #4 clk = ~clk;

  int checks = 0, fails = 0, cyc = 0;
  bit rand_ticks = 0, started = 0, done = 0;

  task automatic check(input string tag, input logic [31:0] a, input logic [31:0] e);
    checks++;
    if (a !== e) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, a, e);
    end
  endtask

  // behavioural reference model
  int m_en[N], m_st[N], m_mode[N], m_act[N];
  int m_sel, m_div, m_err, m_gate, m_s1, m_s2, m_cnt, m_fclk;

  always @(posedge clk) begin
    int n_st[N], n_act[N];
    int any, tk, n_gate, n_s1, n_s2, n_cnt, n_fclk, bsy;
    if (rst) begin
      for (int i = 0; i < N; i++) begin
        m_en[i] = 0; m_st[i] = 0; m_mode[i] = 0; m_act[i] = 0;
      end
      m_sel = 0; m_div = 0; m_err = 0; m_gate = 0; m_s1 = 0; m_s2 = 0;
      m_cnt = 0; m_fclk = 0;
    end else begin
      any = 0;
      for (int i = 0; i < N; i++) if (m_st[i] != 0) any = 1;
      tk = m_sel ? int'(src2) : int'(src1);
      for (int i = 0; i < N; i++) begin
        if (!m_s2) n_act[i] = 0;
        else if (m_st[i] == 1) n_act[i] = 1;
        else if (m_st[i] == 0) n_act[i] = 2;
        else n_act[i] = 3;
        n_st[i] = m_st[i];
        if (m_st[i] == 0 && m_en[i]) n_st[i] = 1;
        else if (m_st[i] == 1 && !m_en[i]) begin
          if (m_mode[i] == 2) n_st[i] = 1;
          else if (m_mode[i] % 2 == 1) n_st[i] = 2;
          else n_st[i] = 0;
        end else if (m_st[i] == 2) begin
          if (m_en[i]) n_st[i] = 1;
          else if (ack[i]) n_st[i] = 0;
        end
      end
      n_gate = (any || (m_gate && wakeup)) ? 1 : 0;
      n_s1 = tk ? m_gate : m_s1;
      n_s2 = tk ? m_s1 : m_s2;
      if (!m_s2) n_cnt = 0;
      else if (tk) n_cnt = (m_cnt == m_div) ? 0 : m_cnt + 1;
      else n_cnt = m_cnt;
      n_fclk = (m_s2 && tk && m_cnt == m_div) ? 1 : 0;
      bsy = m_gate || m_s1 || m_s2;
      for (int i = 0; i < N; i++) bsy = bsy || m_en[i];
      if (wr_en) begin
        if (wr_addr == 0) for (int i = 0; i < N; i++) m_en[i] = (wr_data >> i) & 1;
        else if (wr_addr == 1) begin
          if (bsy) m_err = 1;
          else begin m_sel = wr_data & 1; m_div = (wr_data >> 1) & 7; end
        end else if (wr_addr == 2)
          for (int i = 0; i < N; i++) m_mode[i] = (wr_data >> (2 * i)) & 3;
      end
      for (int i = 0; i < N; i++) begin m_st[i] = n_st[i]; m_act[i] = n_act[i]; end
      m_gate = n_gate; m_s1 = n_s1; m_s2 = n_s2; m_cnt = n_cnt; m_fclk = n_fclk;
    end
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    int ea, er;
    if (started && !done) begin
      ea = 0; er = 0;
      for (int i = 0; i < N; i++) begin
        ea = ea | (m_act[i] << (2 * i));
        if (m_st[i] == 2) er = er | (1 << i);
      end
      check("R6 fclk_tick", 32'(fclk), 32'(m_fclk));
      check("R8 clk_running", 32'(running), 32'(m_s2));
      check("R4 idle_req", 32'(idle_req), 32'(er));
      check("R9 act_status", 32'(act), 32'(ea));
      check("R7 cfg_err", 32'(err), 32'(m_err));
    end
  end

  // source tick generator
  always @(negedge clk) begin
    if (rand_ticks) begin
      src1 = 1'($urandom); src2 = 1'($urandom);
    end else begin
      src1 = ~src1; src2 = 1'b1;
    end
  end

  task automatic finish_run();
    done = 1;
    $display("  %0d/%0d checks passed", checks - fails, checks);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000 && !done) begin
      checks++; fails++;
      $display("FAIL R1 watchdog expired actual=%0d expected<=100000", cyc);
      finish_run();
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1; wr_addr = a; wr_data = d;
    @(negedge clk); wr_en = 0;
  endtask

  task automatic count_ticks(input int win, output int n);
    n = 0;
    repeat (win) begin @(negedge clk); if (fclk) n++; end
  endtask

  initial begin
    int n;
    step(4);
    rst = 0;
    started = 1;
    step(1);
    // R10 reset state
    check("R10 running", 32'(running), 0);
    check("R10 fclk", 32'(fclk), 0);
    check("R10 act", 32'(act), 0);
    check("R10 err", 32'(err), 0);
    check("R10 idle_req", 32'(idle_req), 0);

    // R1/R6: source 1, divide by 3, module 1 forced-idle
    wr(1, 8'h04);
    wr(0, 8'h02);
    step(20);
    check("R1 running after enable", 32'(running), 1);
    check("R9 claimed module code", 32'(act[3:2]), 2'b01);
    check("R9 idle module code", 32'(act[1:0]), 2'b10);
    count_ticks(30, n);
    check("R6 src1 div3 rate", 32'(n), 5);

    // R7: config write while enabled is dropped
    wr(1, 8'h01);
    step(2);
    check("R7 error set", 32'(err), 1);
    count_ticks(30, n);
    check("R7 rate unchanged", 32'(n), 5);

    // R3: forced-idle release
    wr(0, 8'h00);
    step(20);
    check("R3 clock stopped", 32'(running), 0);

    // R6: source 2, divide by 1
    wr(1, 8'h01);
    check("R7 error sticky", 32'(err), 1);
    wr(0, 8'h02);
    step(20);
    count_ticks(30, n);
    check("R6 src2 div1 rate", 32'(n), 30);
    wr(0, 8'h00);
    step(20);

    // R5/R4: module 0 no-idle, module 2 smart-idle
    wr(2, 8'h12);
    wr(0, 8'h05);
    step(10);
    wr(0, 8'h00);
    step(20);
    check("R5 clock kept", 32'(running), 1);
    check("R5 no-idle claim", 32'(act[1:0]), 2'b01);
    check("R4 idle request", 32'(idle_req[2]), 1);
    check("R9 pending code", 32'(act[5:4]), 2'b11);
    wr(2, 8'h10);
    step(20);
    check("R4 held until ack", 32'(running), 1);
    @(negedge clk); ack = 4'b0100;
    @(negedge clk); ack = 4'b0000;
    step(20);
    check("R4 stopped after ack", 32'(running), 0);
    check("R4 request cleared", 32'(idle_req), 0);

    // R2: wakeup holds a running clock
    wr(0, 8'h02);
    step(20);
    @(negedge clk); wakeup = 1;
    wr(0, 8'h00);
    step(20);
    check("R2 held by wakeup", 32'(running), 1);
    @(negedge clk); wakeup = 0;
    step(20);
    check("R2 released", 32'(running), 0);

    // random traffic against the reference model
    rand_ticks = 1;
    for (int k = 0; k < 4000; k++) begin
      @(negedge clk);
      wr_en = (($urandom % 8) == 0);
      wr_addr = 2'($urandom);
      wr_data = 8'($urandom);
      ack = 4'($urandom);
      if (($urandom % 16) == 0) wakeup = ~wakeup;
    end
    @(negedge clk); wr_en = 0;
    step(5);
    finish_run();
  end
endmodule